// File: doc/BRIEF.md
# Non-Volatile Byte and Row Write Controller

This block stands between a CPU-side register port and a small non-volatile data array. The array is modelled here as a register array, and a write-time counter stands in for the programming delay. A control register carries five bits: a write enable, a read-only busy flag, a row-mode enable, a row-start bit and a standby bit. Software can program one byte at a time. It can also collect up to eight bytes of one row in volatile latches and then program them all together.

A single byte write is accepted only while the enable bit is set. It keeps the block busy for `PROG_CYCLES` clock cycles, and the array takes the new value when the busy period ends. In row mode, the first array write after row mode is switched on fixes the row, taken from the upper address bits. Later writes to the same row fill latches at full speed. Setting the start bit programs the whole row at once. Bytes that were not written become FFh.

Requests arrive on a valid/ready port whose ready is held high. The block never applies back-pressure: every valid cycle is taken, and a request that is refused (busy, standby, write enable off, wrong row) is consumed with no effect. Each accepted read returns exactly one response on `rsp_valid` in the next cycle. The response port has no ready, so the consumer must take it.

Top module: `nvm_wr_ctrl`

## Requirements
- R1: After reset, the control register reads 00h, `busy_o` is low and every array byte reads FFh.
- R2: An array write while the write enable (bit 0) is 0 leaves the array unchanged and does not raise `busy_o`.
- R3: An accepted byte write holds `busy_o` high for exactly `PROG_CYCLES` cycles. After that, the byte reads back with the written value.
- R4: While busy, control register writes are ignored and a control read returns 02h (only the busy bit).
- R5: While busy, array writes are dropped and array reads return 00h. The write already in progress still completes.
- R6: Setting row mode (bit 2) clears all row latches to FFh. The first array write then fixes the row from address bits [7:3], and writes to other rows are ignored. While row mode is on, the latched row reads back its latch contents and any other address reads 00h. Latch writes do not raise `busy_o`.
- R7: The start bit (bit 3) is accepted only if the written value has bit 0 and bit 2 set and row mode was already on. Otherwise no programming starts and the start bit stays 0.
- R8: An accepted start writes every byte of the latched row together after `PROG_CYCLES` cycles. Written bytes take their latch value and all others become FFh. When programming ends, both row mode and the start bit clear.
- R9: Clearing row mode before a start abandons the row and leaves the array unchanged.
- R10: While standby (bit 6) is set, array writes have no effect and array reads return 00h.
- R11: Outside busy, a control read returns standby in bit 6, start in bit 3, row mode in bit 2, busy in bit 1 and write enable in bit 0. Bits 7, 5 and 4 always read 0.
- R12: Each accepted read gives exactly one response, with `rsp_valid` high in the next cycle. Writes give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1; requests are never stalled |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ctrl | input | 1 | 1 = control register, 0 = array |
| req_addr | input | ADDR_W | Array byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 8 | Read response data |
| busy_o | output | 1 | Programming in progress |

## Verification
The bench builds the block with `PROG_CYCLES` set to 12 and keeps the default 8-bit address and 8-byte rows. With the short programming time, the bench can count the exact length of the busy window and still fit several aborted accesses inside it. The full address space gives three distinct rows (18h, 28h and 30h) for the tests of row fixing, latch clearing and abandoned rows.

// File: rtl/nvm_wr_pkg.sv
package nvm_wr_pkg;
  localparam int CB_EN = 0;
  localparam int CB_BS = 1;
  localparam int CB_PE = 2;
  localparam int CB_PS = 3;
  localparam int CB_SB = 6;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;
  localparam logic [7:0] ABORT_BYTE  = 8'h00;
  localparam logic [7:0] BUSY_VIEW   = 8'h02;

  typedef struct packed {
    logic sb;
    logic ps;
    logic pe;
    logic en;
  } ctrl_wr_t;
endpackage

// File: rtl/nvm_wr_ctrl_reg.sv
module nvm_wr_ctrl_reg
  import nvm_wr_pkg::*;
#(
  parameter int PROG_CYCLES = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_ctrl,
  input  ctrl_wr_t wval,
  input  logic     start_byte,
  output logic     en,
  output logic     pe,
  output logic     ps,
  output logic     sb,
  output logic     busy,
  output logic     pe_set,
  output logic     done
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          ps_ok;

  assign ps_ok  = wr_ctrl && !busy && wval.ps && wval.en && wval.pe && pe;
  assign pe_set = wr_ctrl && !busy && wval.pe && !pe;
  assign done   = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; pe <= 1'b0; ps <= 1'b0; sb <= 1'b0;
      busy <= 1'b0; cnt <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        ps   <= 1'b0;
        pe   <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (wr_ctrl) begin
      en <= wval.en;
      pe <= wval.pe;
      sb <= wval.sb;
      if (ps_ok) begin
        ps   <= 1'b1;
        busy <= 1'b1;
        cnt  <= LOAD;
      end
    end else if (start_byte) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end
  end

  // R4: software-owned fields are frozen during a busy window
  p_ctrl_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({sb, en}));
  // R7: start only rises with row mode already on and enable set
  p_ps_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps) |-> ($past(pe) && en));
  // R8: end of programming drops row mode and start
  p_end_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!pe && !ps));
endmodule

// File: rtl/nvm_wr_row_buf.sv
module nvm_wr_row_buf
  import nvm_wr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ROW_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  output logic                    hit,
  output logic                    can_take,
  output logic [ADDR_W-ROW_W-1:0] row_addr,
  output logic [7:0]              rd_data,
  output logic [(8<<ROW_W)-1:0]   row_data
);
  localparam int ROWN = 1 << ROW_W;
  localparam int HI_W = ADDR_W - ROW_W;

  logic            row_valid;
  logic [7:0]      lat [ROWN];
  logic [HI_W-1:0] addr_hi;
  logic [ROW_W-1:0] addr_lo;

  assign addr_hi  = addr[ADDR_W-1:ROW_W];
  assign addr_lo  = addr[ROW_W-1:0];
  assign hit      = row_valid && (addr_hi == row_addr);
  assign can_take = !row_valid || hit;
  assign rd_data  = lat[addr_lo];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_valid <= 1'b0;
      row_addr  <= '0;
    end else if (clr) begin
      row_valid <= 1'b0;
    end else if (wr && !row_valid) begin
      row_valid <= 1'b1;
      row_addr  <= addr_hi;
    end
  end

  for (genvar i = 0; i < ROWN; i++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   lat[i] <= ERASED_BYTE;
      else if (clr)                                 lat[i] <= ERASED_BYTE;
      else if (wr && (addr_lo == ROW_W'(i)))        lat[i] <= wdata;
    end
    assign row_data[i*8 +: 8] = lat[i];
  end

  // R6: a fixed row stays fixed until row mode is re-armed
  p_row_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && !clr) |=> $stable(row_addr));
endmodule

// File: rtl/nvm_wr_array.sv
module nvm_wr_array
  import nvm_wr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ROW_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    byte_we,
  input  logic [ADDR_W-1:0]       byte_addr,
  input  logic [7:0]              byte_data,
  input  logic                    row_we,
  input  logic [ADDR_W-ROW_W-1:0] row_sel,
  input  logic [(8<<ROW_W)-1:0]   row_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ROWN  = 1 << ROW_W;

  logic [7:0] mem [DEPTH];

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= ERASED_BYTE;
    end else if (byte_we) begin
      mem[byte_addr] <= byte_data;
    end else if (row_we) begin
      for (int j = 0; j < ROWN; j++)
        mem[{row_sel, ROW_W'(j)}] <= row_data[j*8 +: 8];
    end
  end
endmodule

// File: rtl/nvm_wr_ctrl.sv
module nvm_wr_ctrl
  import nvm_wr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int ROW_W       = 3,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_ctrl,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              busy_o
);
  localparam int HI_W = ADDR_W - ROW_W;

  logic en, pe, ps, sb, busy, pe_set, done;
  logic wr_ctrl, arr_wr, byte_start, lat_wr, rd_req;
  logic hit, can_take;
  logic [HI_W-1:0]        row_addr;
  logic [7:0]             lat_rd, arr_rd, rd_mux;
  logic [(8<<ROW_W)-1:0]  row_data;
  logic [ADDR_W-1:0]      pend_addr;
  logic [7:0]             pend_data;
  ctrl_wr_t               wval;

  assign req_ready  = 1'b1;
  assign wr_ctrl    = req_valid && req_write && req_ctrl;
  assign arr_wr     = req_valid && req_write && !req_ctrl && !busy && en && !sb;
  assign byte_start = arr_wr && !pe;
  assign lat_wr     = arr_wr && pe && can_take;
  assign rd_req     = req_valid && !req_write;
  assign busy_o     = busy;
  assign wval       = '{sb: req_wdata[CB_SB], ps: req_wdata[CB_PS],
                        pe: req_wdata[CB_PE], en: req_wdata[CB_EN]};

  nvm_wr_ctrl_reg #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wval(wval),
    .start_byte(byte_start), .en(en), .pe(pe), .ps(ps), .sb(sb),
    .busy(busy), .pe_set(pe_set), .done(done)
  );

  nvm_wr_row_buf #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .clr(pe_set), .wr(lat_wr), .addr(req_addr),
    .wdata(req_wdata), .hit(hit), .can_take(can_take), .row_addr(row_addr),
    .rd_data(lat_rd), .row_data(row_data)
  );

  nvm_wr_array #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .byte_we(done && !ps), .byte_addr(pend_addr), .byte_data(pend_data),
    .row_we(done && ps), .row_sel(row_addr), .row_data(row_data),
    .rd_addr(req_addr), .rd_data(arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr <= '0;
      pend_data <= '0;
    end else if (byte_start) begin
      pend_addr <= req_addr;
      pend_data <= req_wdata;
    end
  end

  always_comb begin
    if (req_ctrl) begin
      if (busy) rd_mux = BUSY_VIEW;
      else      rd_mux = {1'b0, sb, 2'b00, ps, pe, busy, en};
    end else if (busy || sb) begin
      rd_mux = ABORT_BYTE;
    end else if (pe) begin
      rd_mux = hit ? lat_rd : ABORT_BYTE;
    end else begin
      rd_mux = arr_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_data <= rd_mux;
    end
  end

  // R2: writes with enable off never start programming
  p_en0_no_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_ctrl && !busy && !en) |=> !busy_o);
  // R10: standby blocks programming
  p_sb_no_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_ctrl && !busy && sb) |=> !busy_o);
  // R5: reads during a busy window are aborted
  p_abort_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_ctrl && busy_o) |=> (rsp_data == ABORT_BYTE));
  // R12: a response only follows a read request
  p_rsp_follows_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
endmodule

// File: tb/nvm_wr_ctrl_tb_top.sv
module nvm_wr_ctrl_tb_top;
  localparam int PROG = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ctrl = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, busy_o;
  logic [7:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  nvm_wr_ctrl #(.ADDR_W(8), .ROW_W(3), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_ctrl(req_ctrl), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy_o(busy_o)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compares each response against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected response", 8'h01, 8'h00);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rsp_data, e);
      end
    end
  end

  task automatic xfer(bit w, bit c, logic [7:0] a, logic [7:0] d,
                      logic [7:0] e, string tag);
    req_valid = 1'b1; req_write = w; req_ctrl = c; req_addr = a; req_wdata = d;
    if (!w) begin exp_q.push_back(e); tag_q.push_back(tag); end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_ctl(logic [7:0] d);                  xfer(1, 1, 8'h00, d, 8'h00, ""); endtask
  task automatic wr_arr(logic [7:0] a, logic [7:0] d);   xfer(1, 0, a, d, 8'h00, ""); endtask
  task automatic rd_ctl(logic [7:0] e, string t);        xfer(0, 1, 8'h00, 8'h00, e, t); endtask
  task automatic rd_arr(logic [7:0] a, logic [7:0] e, string t); xfer(0, 0, a, 8'h00, e, t); endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 busy after reset", {7'b0, busy_o}, 8'h00);
    check("R12 ready high", {7'b0, req_ready}, 8'h01);
    rd_ctl(8'h00, "R1 control reset value");
    rd_arr(8'h10, 8'hFF, "R1 array erased");

    wr_arr(8'h10, 8'h5A);
    check("R2 no busy with enable off", {7'b0, busy_o}, 8'h00);
    rd_arr(8'h10, 8'hFF, "R2 array untouched");

    wr_ctl(8'h01);
    rd_ctl(8'h01, "R11 enable bit");
    wr_ctl(8'hB1);
    rd_ctl(8'h01, "R11 bits 7,5,4 read zero");

    wr_arr(8'h10, 8'h5A);
    wait_idle(n);
    check("R3 busy length", 8'(n), 8'(PROG));
    rd_arr(8'h10, 8'h5A, "R3 byte readback");

    wr_arr(8'h20, 8'hC3);
    wr_ctl(8'h40);
    rd_ctl(8'h02, "R4 busy view of control");
    wr_arr(8'h21, 8'h11);
    rd_arr(8'h20, 8'h00, "R5 aborted read");
    wait_idle(n);
    rd_ctl(8'h01, "R4 control write ignored");
    rd_arr(8'h20, 8'hC3, "R5 running write completes");
    rd_arr(8'h21, 8'hFF, "R5 aborted write dropped");

    wr_arr(8'h19, 8'h33);
    wait_idle(n);

    wr_ctl(8'h09);
    check("R7 start without row mode", {7'b0, busy_o}, 8'h00);
    rd_ctl(8'h01, "R7 start bit stays clear");

    wr_ctl(8'h05);
    rd_ctl(8'h05, "R11 row mode bit");
    wr_arr(8'h1A, 8'hA1);
    wr_arr(8'h18, 8'hA2);
    wr_arr(8'h1B, 8'hA3);
    wr_arr(8'h28, 8'h77);
    check("R6 latch writes not busy", {7'b0, busy_o}, 8'h00);
    rd_arr(8'h1A, 8'hA1, "R6 latch readback");
    rd_arr(8'h19, 8'hFF, "R6 unwritten latch");
    rd_arr(8'h28, 8'h00, "R6 other row hidden");
    wr_ctl(8'h0C);
    check("R7 start with enable off", {7'b0, busy_o}, 8'h00);
    rd_ctl(8'h04, "R7 start rejected");
    wr_ctl(8'h0D);
    wait_idle(n);
    check("R8 row busy length", 8'(n), 8'(PROG));
    rd_ctl(8'h01, "R8 row mode and start cleared");
    rd_arr(8'h18, 8'hA2, "R8 row byte 0");
    rd_arr(8'h1A, 8'hA1, "R8 row byte 2");
    rd_arr(8'h1B, 8'hA3, "R8 row byte 3");
    rd_arr(8'h19, 8'hFF, "R8 unwritten byte erased");
    rd_arr(8'h1F, 8'hFF, "R8 unwritten byte 7");
    rd_arr(8'h28, 8'hFF, "R6 other row write ignored");

    wr_ctl(8'h05);
    wr_arr(8'h30, 8'h99);
    wr_ctl(8'h01);
    check("R9 abandon not busy", {7'b0, busy_o}, 8'h00);
    rd_arr(8'h30, 8'hFF, "R9 array unchanged");
    wr_ctl(8'h05);
    rd_arr(8'h30, 8'h00, "R6 no row fixed yet");
    wr_arr(8'h31, 8'h44);
    rd_arr(8'h30, 8'hFF, "R6 latches cleared on re-arm");
    rd_arr(8'h31, 8'h44, "R6 new latch value");
    wr_ctl(8'h01);
    rd_arr(8'h31, 8'hFF, "R9 second abandon");

    wr_ctl(8'h41);
    rd_ctl(8'h41, "R11 standby bit");
    wr_arr(8'h40, 8'h12);
    check("R10 standby no busy", {7'b0, busy_o}, 8'h00);
    rd_arr(8'h10, 8'h00, "R10 standby read");
    wr_ctl(8'h01);
    rd_arr(8'h40, 8'hFF, "R10 standby write ignored");
    rd_arr(8'h10, 8'h5A, "R10 data kept");

    repeat (3) @(negedge clk);
    check("R12 all responses seen", 8'(exp_q.size()), 8'h00);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule